// File: doc/BRIEF.md
# Channel Priority Arbiter

This block decides which of up to eight DMA channels gets the bus next. Each channel presents a request line, an enable and a suspend flag. It also has a small priority value held inside the block and loaded through a single-cycle write port. At each arbitration point the block compares priority values among the eligible channels, where a smaller value is more urgent. Among equal values the lower channel index wins. The block then registers a one-hot grant, the encoded winner and a valid flag.

A grant stays fixed for the whole transaction. The block only arbitrates again when no grant is outstanding, or when the bus side pulses `xfer_done` for the granted transaction. Priority values written while a transaction is running are stored at once but only affect the next arbitration. All priorities reset to zero, so an unprogrammed block orders channels by index alone.

Top module: `chan_prio_arbiter`

## Requirements
- R1: While `rst_n` is low and after its release with no requests, `grant` is all zeros, `grant_valid` is 0 and `grant_idx` is 0. Every priority value resets to 0.
- R2: A channel is eligible only when its `req` bit is 1, its `enable` bit is 1 and its `suspend` bit is 0. A channel that is not eligible at an arbitration point is never granted at that point.
- R3: Among eligible channels, the one whose priority value is numerically smallest wins. Value 0 is the most urgent and NUM_CH-1 the least urgent.
- R4: When several eligible channels share the smallest priority value, the one with the lowest index wins.
- R5: With all priority values at their reset value, the lowest-index eligible channel wins (for example, channel 2 beats channel 4).
- R6: `grant` is one-hot or zero. Bit `grant_idx` of `grant` is set whenever `grant_valid` is 1. `grant_valid` is 1 exactly when `grant` is non-zero.
- R7: If no channel is eligible at an arbitration point, then one cycle later `grant` is all zeros and `grant_valid` is 0.
- R8: An arbitration point is a rising clock edge at which `grant_valid` is 0 or `xfer_done` is 1. The result appears on the outputs after that edge. At every other edge, `grant` and `grant_idx` keep their values, whatever the request, enable or suspend inputs do.
- R9: With `cfg_we` at 1, the rising edge stores `cfg_prio` as the priority of channel `cfg_sel`. A grant outstanding at that time is not changed, and the new value is used from the next arbitration point on.
- R10: At an arbitration point, the channel just served competes like any other channel. If it is still the best eligible channel, it is granted again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | NUM_CH | Per-channel service request |
| enable | input | NUM_CH | Per-channel enable |
| suspend | input | NUM_CH | Per-channel suspend; a suspended channel is not granted |
| cfg_we | input | 1 | Priority write strobe |
| cfg_sel | input | IDX_W | Channel whose priority is written |
| cfg_prio | input | PRIO_W | Priority value to write; 0 is most urgent |
| xfer_done | input | 1 | Granted transaction finishes; allows re-arbitration |
| grant | output | NUM_CH | One-hot grant |
| grant_valid | output | 1 | A grant is outstanding |
| grant_idx | output | IDX_W | Index of the granted channel |

## Verification
The bench builds the block with its default of eight channels, so priority fields are three bits wide and span the full legal range 0 to 7. This makes it possible to test the least urgent value, ties among three channels, and an urgent high-index channel beating low-index ones. The same width lets the bench make a high-index channel win on priority against lower-index rivals, while a held grant ignores a newly arriving more urgent channel until `xfer_done`.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int unsigned ARB_MAX_CH = 8;

  function automatic int unsigned field_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/arb_prio_regs.sv
module arb_prio_regs #(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned PRIO_W = 3,
  parameter int unsigned IDX_W  = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [IDX_W-1:0]         sel,
  input  logic [PRIO_W-1:0]        wdata,
  output logic [NUM_CH*PRIO_W-1:0] prio_flat
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic              hit;
    logic [PRIO_W-1:0] prio_q;
    logic [PRIO_W-1:0] prio_d;

    assign hit = we && (sel == IDX_W'(c));

    always_comb begin
      prio_d = prio_q;
      if (hit) prio_d = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prio_q <= '0;
      end else if (hit) begin
        prio_q <= prio_d;
      end
    end

    assign prio_flat[c*PRIO_W +: PRIO_W] = prio_q;
  end
endmodule

// File: rtl/arb_prio_pick.sv
module arb_prio_pick #(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned PRIO_W = 3,
  parameter int unsigned IDX_W  = 3
) (
  input  logic [NUM_CH-1:0]        elig,
  input  logic [NUM_CH*PRIO_W-1:0] prio_flat,
  output logic                     found,
  output logic [IDX_W-1:0]         win_idx,
  output logic [NUM_CH-1:0]        win_oh
);
  logic              seen  [0:NUM_CH];
  logic [PRIO_W-1:0] bestp [0:NUM_CH];
  logic [IDX_W-1:0]  besti [0:NUM_CH];

  assign seen[0]  = 1'b0;
  assign bestp[0] = '0;
  assign besti[0] = '0;

  // Ascending scan; strict "<" keeps the lower index on a tie.
  for (genvar c = 0; c < NUM_CH; c++) begin : g_stage
    logic [PRIO_W-1:0] p;
    logic              take;
    assign p    = prio_flat[c*PRIO_W +: PRIO_W];
    assign take = elig[c] && (!seen[c] || (p < bestp[c]));
    assign seen[c+1]  = seen[c] || elig[c];
    assign bestp[c+1] = take ? p : bestp[c];
    assign besti[c+1] = take ? IDX_W'(c) : besti[c];
  end

  assign found   = seen[NUM_CH];
  assign win_idx = besti[NUM_CH];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_oh
    assign win_oh[c] = found && (win_idx == IDX_W'(c));
  end
endmodule

// File: rtl/arb_grant_hold.sv
module arb_grant_hold #(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arb_en,
  input  logic              found,
  input  logic [IDX_W-1:0]  win_idx,
  input  logic [NUM_CH-1:0] win_oh,
  output logic [NUM_CH-1:0] grant,
  output logic              grant_valid,
  output logic [IDX_W-1:0]  grant_idx
);
  logic [NUM_CH-1:0] grant_q, grant_d;
  logic              valid_q, valid_d;
  logic [IDX_W-1:0]  idx_q, idx_d;

  always_comb begin
    grant_d = win_oh;
    valid_d = found;
    idx_d   = found ? win_idx : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_q <= '0;
      valid_q <= 1'b0;
      idx_q   <= '0;
    end else if (arb_en) begin
      grant_q <= grant_d;
      valid_q <= valid_d;
      idx_q   <= idx_d;
    end
  end

  assign grant       = grant_q;
  assign grant_valid = valid_q;
  assign grant_idx   = idx_q;
endmodule

// File: rtl/chan_prio_arbiter.sv
module chan_prio_arbiter #(
  parameter int unsigned NUM_CH = arb_pkg::ARB_MAX_CH,
  parameter int unsigned PRIO_W = arb_pkg::field_width(NUM_CH),
  parameter int unsigned IDX_W  = arb_pkg::field_width(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] req,
  input  logic [NUM_CH-1:0] enable,
  input  logic [NUM_CH-1:0] suspend,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_sel,
  input  logic [PRIO_W-1:0] cfg_prio,
  input  logic              xfer_done,
  output logic [NUM_CH-1:0] grant,
  output logic              grant_valid,
  output logic [IDX_W-1:0]  grant_idx
);
  logic [NUM_CH*PRIO_W-1:0] prio_flat;
  logic [NUM_CH-1:0]        elig;
  logic                     arb_en;
  logic                     found;
  logic [IDX_W-1:0]         win_idx;
  logic [NUM_CH-1:0]        win_oh;

  assign elig   = req & enable & ~suspend;
  assign arb_en = !grant_valid || xfer_done;

  arb_prio_regs #(.NUM_CH(NUM_CH), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (cfg_we),
    .sel       (cfg_sel),
    .wdata     (cfg_prio),
    .prio_flat (prio_flat)
  );

  arb_prio_pick #(.NUM_CH(NUM_CH), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_pick (
    .elig      (elig),
    .prio_flat (prio_flat),
    .found     (found),
    .win_idx   (win_idx),
    .win_oh    (win_oh)
  );

  arb_grant_hold #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_hold (
    .clk         (clk),
    .rst_n       (rst_n),
    .arb_en      (arb_en),
    .found       (found),
    .win_idx     (win_idx),
    .win_oh      (win_oh),
    .grant       (grant),
    .grant_valid (grant_valid),
    .grant_idx   (grant_idx)
  );
endmodule

// File: rtl/arb_checker.sv
module arb_checker #(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned IDX_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] req,
  input logic [NUM_CH-1:0] enable,
  input logic [NUM_CH-1:0] suspend,
  input logic              xfer_done,
  input logic [NUM_CH-1:0] grant,
  input logic              grant_valid,
  input logic [IDX_W-1:0]  grant_idx
);
  logic [NUM_CH-1:0] ok_ch;
  logic              arb_pt;
  assign ok_ch  = req & enable & ~suspend;
  assign arb_pt = !grant_valid || xfer_done;

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R6

  AST_VALID_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid == (grant != '0)); // R6

  AST_IDX_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> (((grant >> grant_idx) & NUM_CH'(1)) != '0)); // R6

  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && !xfer_done) |=> ($stable(grant) && $stable(grant_idx))); // R8

  AST_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    arb_pt |=> (!grant_valid || ((($past(ok_ch) >> grant_idx) & NUM_CH'(1)) != '0))); // R2

  AST_IDLE_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_pt && (ok_ch == '0)) |=> !grant_valid); // R7
endmodule

bind chan_prio_arbiter arb_checker #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req         (req),
  .enable      (enable),
  .suspend     (suspend),
  .xfer_done   (xfer_done),
  .grant       (grant),
  .grant_valid (grant_valid),
  .grant_idx   (grant_idx)
);

// File: tb/tb_chan_prio_arbiter.sv
module tb_chan_prio_arbiter;
  localparam int NCH = 8;
  localparam int IW  = 3;
  localparam int PW  = 3;

  logic           clk;
  logic           rst_n;
  logic [NCH-1:0] req, enable, suspend;
  logic           cfg_we;
  logic [IW-1:0]  cfg_sel;
  logic [PW-1:0]  cfg_prio;
  logic           xfer_done;
  logic [NCH-1:0] grant;
  logic           grant_valid;
  logic [IW-1:0]  grant_idx;

  int checks = 0;
  int errors = 0;

  chan_prio_arbiter dut (
    .clk(clk), .rst_n(rst_n), .req(req), .enable(enable), .suspend(suspend),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_prio(cfg_prio), .xfer_done(xfer_done),
    .grant(grant), .grant_valid(grant_valid), .grant_idx(grant_idx)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // {req, enable, suspend, exp_valid, exp_idx}; priorities 5,2,2,7,0,3,2,6 for ch0..ch7
  localparam logic [27:0] VEC [0:10] = '{
    {8'hFF, 8'hFF, 8'h00, 1'b1, 3'd4},
    {8'hEF, 8'hFF, 8'h00, 1'b1, 3'd1},
    {8'hED, 8'hFF, 8'h00, 1'b1, 3'd2},
    {8'hC9, 8'hFF, 8'h00, 1'b1, 3'd6},
    {8'h89, 8'hFF, 8'h00, 1'b1, 3'd0},
    {8'h88, 8'hFF, 8'h00, 1'b1, 3'd7},
    {8'hFF, 8'hEF, 8'h00, 1'b1, 3'd1},
    {8'hFF, 8'hFF, 8'h16, 1'b1, 3'd6},
    {8'h00, 8'hFF, 8'h00, 1'b0, 3'd0},
    {8'hFF, 8'h00, 8'h00, 1'b0, 3'd0},
    {8'h08, 8'hFF, 8'h00, 1'b1, 3'd3}
  };
  localparam logic [PW-1:0] TPRIO [0:7] = '{3'd5, 3'd2, 3'd2, 3'd7, 3'd0, 3'd3, 3'd2, 3'd6};

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input logic ev, input logic [IW-1:0] ei);
    logic [NCH-1:0] eg;
    eg = ev ? (NCH'(1) << ei) : '0;
    checks++;
    if (grant !== eg || grant_valid !== ev || (ev && grant_idx !== ei)) begin
      errors++;
      $display("FAIL %s: grant=%b valid=%b idx=%0d expected grant=%b valid=%b idx=%0d",
               tag, grant, grant_valid, grant_idx, eg, ev, ei);
    end
  endtask

  task automatic wr_prio(input int ch, input logic [PW-1:0] p);
    cfg_we = 1'b1; cfg_sel = IW'(ch); cfg_prio = p;
    step();
    cfg_we = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req = '0; enable = '1; suspend = '0;
    cfg_we = 1'b0; cfg_sel = '0; cfg_prio = '0; xfer_done = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 in reset", 1'b0, 3'd0);
    @(negedge clk); rst_n = 1'b1;
    step();
    check("R1 after reset", 1'b0, 3'd0);

    // R5: reset priorities give index order
    xfer_done = 1'b1; req = 8'h14; step();
    check("R5 ch2 beats ch4", 1'b1, 3'd2);
    req = 8'hFF; step();
    check("R5 all request", 1'b1, 3'd0);
    req = 8'h00; step();
    check("R7 release", 1'b0, 3'd0);

    // R8: grant held until done
    xfer_done = 1'b0; req = 8'h10; step();
    check("R8 grant from idle", 1'b1, 3'd4);
    req = 8'h01; step();
    check("R8 held vs new urgent req", 1'b1, 3'd4);
    enable = 8'hEF; step();
    check("R8 held after enable drop", 1'b1, 3'd4);
    enable = 8'hFF; xfer_done = 1'b1; step();
    check("R8 done re-arbitrates", 1'b1, 3'd0);
    xfer_done = 1'b0;

    // R9: priority write mid-transaction
    req = 8'h03;
    wr_prio(0, 3'd7);
    check("R9 write leaves grant", 1'b1, 3'd0);
    step();
    check("R9 still held", 1'b1, 3'd0);
    xfer_done = 1'b1; step();
    check("R9 new value at arb point", 1'b1, 3'd1);

    // R10: served channel competes again
    step();
    check("R10 same channel regranted", 1'b1, 3'd1);

    // table walk: R2 R3 R4 R7
    req = 8'h00;
    for (int c = 0; c < NCH; c++) wr_prio(c, TPRIO[c]);
    for (int v = 0; v < 11; v++) begin
      req = VEC[v][27:20]; enable = VEC[v][19:12]; suspend = VEC[v][11:4];
      step();
      check($sformatf("R2/R3/R4/R7 vector %0d", v), VEC[v][3], VEC[v][2:0]);
    end

    // R4: three-way tie on value 2 with ch1 suspended
    req = 8'h46; enable = 8'hFF; suspend = 8'h02; step();
    check("R4 tie lower index", 1'b1, 3'd2);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule